// File: doc/BRIEF.md
# Banked Scratchpad Read Serializer

This block is a word-interleaved scratchpad made of sixteen 32-bit banks. It serves gathered reads for a group of sixteen lanes. Each lane has an enable bit and a word address. The low four address bits select the bank. The bits above them select the row inside that bank. A request is accepted in one cycle. The block then runs as many internal passes as the busiest bank needs. In each pass every bank delivers one word.

Lanes that map to the same bank at different addresses are spread over successive passes. Lanes that ask for the very same word are served together in one pass as a broadcast, so they cost nothing extra. Inside a bank, each pass takes the address of the lowest-numbered lane still waiting, and serves every waiting lane that wants that word. When the last pass ends, the block pulses a done flag. It then presents the read data of every lane and the number of passes it used. A separate single-lane write port loads the memory.

Top module: `bsp_conflict_ser`

## Requirements
- R1: A word address `a` maps to bank `a[3:0]` and row `a[7:4]`. A write with `wr_en` high stores `wr_data` at that bank and row on the clock edge. Two lanes whose addresses differ only in bits [7:4] share a bank.
- R2: When every enabled lane maps to a different bank, the request completes in one pass. A unit stride and a stride of 17 words both behave this way.
- R3: The pass count equals the largest number of distinct addresses that the enabled lanes place on any single bank. Strides of 2, 4, 8 and 16 words give 2, 4, 8 and 16 passes.
- R4: Enabled lanes that carry the same address are served in the same pass and count once. All lanes on one address take one pass. A stride of 32 words, which repeats every 8 lanes on one bank, takes 8 passes.
- R5: A lane whose enable bit is 0 returns zero data. It does not add to the pass count.
- R6: `req_ready` drops in the cycle after a request is accepted and stays low until the response. `rsp_done` is a single-cycle pulse, seen max(P,1) clock edges after the accepting edge, where P is the pass count. `req_ready` is high again in the same cycle as `rsp_done`.
- R7: A request with no enabled lanes completes with a pass count of 0, one edge after acceptance.
- R8: After reset, `req_ready` is 1, `rsp_done` is 0, `rsp_data` is all zeros and `rsp_passes` is 0.
- R9: `rsp_data` and `rsp_passes` hold their values after the done pulse until the next request is accepted.
- R10: Lane l takes its enable from `req_lane_en[l]` and its address from `req_addr[l*8 +: 8]`. It returns the memory word at that address in `rsp_data[l*32 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_lane_en | input | 16 | Per-lane enable |
| req_addr | input | 128 | Per-lane word address, 8 bits per lane |
| wr_en | input | 1 | Write strobe for the fill port |
| wr_addr | input | 8 | Word address of the write |
| wr_data | input | 32 | Word to store |
| rsp_done | output | 1 | One-cycle pulse when all lanes are served |
| rsp_data | output | 512 | Per-lane read data, 32 bits per lane |
| rsp_passes | output | 5 | Passes used by the last request |

## Verification
Suppose the pending-lane mask is wrong, for example a lane is not cleared when served. The done pulse then never comes, or comes late, and the latency check catches this within one request. Suppose instead the per-bank pick goes wrong, so it merges lanes with different rows or splits a broadcast. Then the pass count differs from the distinct-address count that the bench computes from the stride pattern. The wrong lane also shows another lane's word at the done pulse. Wrong bank or row decoding shows up when the response data is compared with the words written through the fill port.

// File: rtl/bsp_pkg.sv
`timescale 1ns/1ps
package bsp_pkg;
   typedef enum logic {
      SER_IDLE = 1'b0,
      SER_BUSY = 1'b1
   } ser_state_e;
endpackage

// File: rtl/bsp_bank.sv
`timescale 1ns/1ps
module bsp_bank #(
   parameter int DATA_W = 32,
   parameter int ROWS   = 16,
   localparam int ROW_W = $clog2(ROWS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ROW_W-1:0]  wr_row,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ROW_W-1:0]  rd_row,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] store [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_row] <= wr_data;
   end

   assign rd_data = store[rd_row];
endmodule

// File: rtl/bsp_pass_pick.sv
`timescale 1ns/1ps
module bsp_pass_pick #(
   parameter int LANES  = 16,
   parameter int BANKS  = 16,
   parameter int ROWS   = 16,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(ROWS),
   localparam int ADDR_W = BANK_W + ROW_W
) (
   input  logic [LANES-1:0]             pending,
   input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
   output logic [LANES-1:0]             served,
   output logic [BANKS-1:0][ROW_W-1:0]  bank_row
);
   always_comb begin
      served   = '0;
      bank_row = '0;
      for (int b = 0; b < BANKS; b++) begin
         logic              found;
         logic [ADDR_W-1:0] pick;
         found = 1'b0;
         pick  = '0;
         // lowest-numbered waiting lane on this bank sets the word
         for (int l = 0; l < LANES; l++) begin
            if (!found && pending[l] && lane_addr[l][BANK_W-1:0] == BANK_W'(b)) begin
               found = 1'b1;
               pick  = lane_addr[l];
            end
         end
         bank_row[b] = pick[ADDR_W-1:BANK_W];
         // every waiting lane on the same word rides along
         for (int l = 0; l < LANES; l++) begin
            if (found && pending[l] && lane_addr[l] == pick) served[l] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bsp_conflict_ser.sv
`timescale 1ns/1ps
module bsp_conflict_ser #(
   parameter int LANES  = 16,
   parameter int BANKS  = 16,
   parameter int ROWS   = 16,
   parameter int DATA_W = 32,
   localparam int BANK_W = $clog2(BANKS),
   localparam int ROW_W  = $clog2(ROWS),
   localparam int ADDR_W = BANK_W + ROW_W,
   localparam int CNT_W  = $clog2(LANES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES-1:0]        req_lane_en,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic                    wr_en,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [DATA_W-1:0]       wr_data,
   output logic                    rsp_done,
   output logic [LANES*DATA_W-1:0] rsp_data,
   output logic [CNT_W-1:0]        rsp_passes
);
   import bsp_pkg::*;

   // elaboration-time parameter checks
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_chk_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (ROWS < 2 || (ROWS & (ROWS - 1)) != 0) begin : g_chk_rows
      $error("ROWS must be a power of two, at least 2");
   end
   if (LANES < 1) begin : g_chk_lanes
      $error("LANES must be at least 1");
   end

   ser_state_e                       state_q;
   logic [LANES-1:0]                 pend_q;
   logic [LANES-1:0][ADDR_W-1:0]     addr_q;
   logic [LANES-1:0][DATA_W-1:0]     data_q;
   logic [CNT_W-1:0]                 passes_q;
   logic                             done_q;

   logic [LANES-1:0]                 served;
   logic [BANKS-1:0][ROW_W-1:0]      bank_row;
   logic [BANKS-1:0][DATA_W-1:0]     bank_rdata;
   logic [LANES-1:0][DATA_W-1:0]     lane_rd;
   logic [LANES-1:0]                 pend_next;

   bsp_pass_pick #(
      .LANES (LANES),
      .BANKS (BANKS),
      .ROWS  (ROWS)
   ) pick_i (
      .pending   (pend_q),
      .lane_addr (addr_q),
      .served    (served),
      .bank_row  (bank_row)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic bank_wr;
      assign bank_wr = wr_en && (wr_addr[BANK_W-1:0] == BANK_W'(b));
      bsp_bank #(
         .DATA_W (DATA_W),
         .ROWS   (ROWS)
      ) bank_i (
         .clk     (clk),
         .wr_en   (bank_wr),
         .wr_row  (wr_addr[ADDR_W-1:BANK_W]),
         .wr_data (wr_data),
         .rd_row  (bank_row[b]),
         .rd_data (bank_rdata[b])
      );
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_rd[l] = bank_rdata[addr_q[l][BANK_W-1:0]];
   end

   assign pend_next = pend_q & ~served;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SER_IDLE;
         pend_q   <= '0;
         addr_q   <= '0;
         data_q   <= '0;
         passes_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SER_IDLE: begin
               if (req_valid) begin
                  for (int l = 0; l < LANES; l++) begin
                     addr_q[l] <= req_addr[l*ADDR_W +: ADDR_W];
                  end
                  pend_q   <= req_lane_en;
                  data_q   <= '0;
                  passes_q <= '0;
                  state_q  <= SER_BUSY;
               end
            end
            default: begin
               if (pend_q != '0) begin
                  passes_q <= passes_q + CNT_W'(1);
                  for (int l = 0; l < LANES; l++) begin
                     if (served[l]) data_q[l] <= lane_rd[l];
                  end
               end
               pend_q <= pend_next;
               if (pend_next == '0) begin
                  state_q <= SER_IDLE;
                  done_q  <= 1'b1;
               end
            end
         endcase
      end
   end

   assign req_ready  = (state_q == SER_IDLE);
   assign rsp_done   = done_q;
   assign rsp_data   = data_q;
   assign rsp_passes = passes_q;

   AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);                       // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);                                       // R6
   AST_DONE_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> req_ready);                                       // R6
   AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_passes <= CNT_W'(LANES));                                  // R3
   AST_PASS_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SER_BUSY && pend_q != '0) |-> (served != '0));     // R3
   AST_SERVE_PENDING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (served & ~pend_q) == '0);                                     // R5
endmodule

// File: tb/bsp_conflict_ser_tb.sv
`timescale 1ns/1ps
module bsp_conflict_ser_tb_top;
   localparam int LANES = 16;
   localparam int AW    = 8;
   localparam int DW    = 32;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req_valid = 1'b0;
   logic                 req_ready;
   logic [LANES-1:0]     req_lane_en = '0;
   logic [LANES*AW-1:0]  req_addr = '0;
   logic                 wr_en = 1'b0;
   logic [AW-1:0]        wr_addr = '0;
   logic [DW-1:0]        wr_data = '0;
   logic                 rsp_done;
   logic [LANES*DW-1:0]  rsp_data;
   logic [4:0]           rsp_passes;

   int n_checks = 0;
   int n_fail   = 0;
   logic [DW-1:0] ref_mem [256];

   always #2.5 clk = ~clk;

   bsp_conflict_ser dut_i (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_ready (req_ready),
      .req_lane_en (req_lane_en), .req_addr (req_addr),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .rsp_done (rsp_done), .rsp_data (rsp_data), .rsp_passes (rsp_passes)
   );

   // {base, stride, lane mask, expected passes}
   localparam int NV = 11;
   localparam logic [36:0] VECS [NV] = '{
      {8'd0, 8'd1,  16'hFFFF, 5'd1},
      {8'd3, 8'd4,  16'hFFFF, 5'd4},
      {8'd0, 8'd16, 16'hFFFF, 5'd16},
      {8'd2, 8'd17, 16'hFFFF, 5'd1},
      {8'd9, 8'd0,  16'hFFFF, 5'd1},
      {8'd0, 8'd2,  16'hFFFF, 5'd2},
      {8'd1, 8'd8,  16'hFFFF, 5'd8},
      {8'd0, 8'd16, 16'h00FF, 5'd8},
      {8'd5, 8'd32, 16'hFFFF, 5'd8},
      {8'd0, 8'd16, 16'h0000, 5'd0},
      {8'd4, 8'd16, 16'h8001, 5'd2}
   };

   function automatic logic [DW-1:0] fill_val(int i);
      return {8'(i), 8'(i ^ 8'h3C), 16'(i * 13 + 7)};
   endfunction

   task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic write_word(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      ref_mem[a] = d;
   endtask

   task automatic data_check(string req, logic [LANES-1:0] en, logic [LANES*AW-1:0] av);
      logic [DW-1:0] act, exp;
      int bad;
      bad = -1;
      for (int l = 0; l < LANES; l++) begin
         act = rsp_data[l*DW +: DW];
         exp = en[l] ? ref_mem[av[l*AW +: AW]] : '0;
         if (act !== exp && bad < 0) bad = l;
      end
      if (bad < 0) check(req, "lane data", 32'd0, 32'd0);
      else check(req, $sformatf("lane %0d data", bad), rsp_data[bad*DW +: DW],
                 en[bad] ? ref_mem[av[bad*AW +: AW]] : '0);
   endtask

   task automatic run_req(string req, logic [LANES-1:0] en, logic [LANES*AW-1:0] av,
                          int exp_passes);
      int cyc;
      @(negedge clk);
      req_valid = 1'b1; req_lane_en = en; req_addr = av;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check("R6", "ready low after accept", 32'(req_ready), 32'd0);
      cyc = 0;
      while (!rsp_done && cyc < 40) begin
         @(posedge clk); @(negedge clk); cyc++;
      end
      check("R6", "done latency", 32'(cyc), 32'((exp_passes > 0) ? exp_passes : 1));
      check(req, "pass count", 32'(rsp_passes), 32'(exp_passes));
      data_check(req, en, av);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_checks++;
      $display("FAIL R6 watchdog actual=hang expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [LANES*AW-1:0] av;
      logic [LANES*DW-1:0] held;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8", "ready", 32'(req_ready), 32'd1);
      check("R8", "done", 32'(rsp_done), 32'd0);
      check("R8", "passes", 32'(rsp_passes), 32'd0);
      check("R8", "data zero", 32'(rsp_data != '0), 32'd0);
      @(negedge clk); rst_n = 1'b1;

      for (int i = 0; i < 256; i++) write_word(8'(i), fill_val(i));

      // table walk: R2, R3, R4, R5, R7, R10
      for (int v = 0; v < NV; v++) begin
         logic [7:0] base, stride;
         logic [15:0] mask;
         logic [4:0] ep;
         {base, stride, mask, ep} = VECS[v];
         for (int l = 0; l < LANES; l++) av[l*AW +: AW] = 8'(base + stride * l);
         case (v)
            0, 3:    run_req("R2", mask, av, int'(ep));
            4, 8:    run_req("R4", mask, av, int'(ep));
            7, 10:   run_req("R5", mask, av, int'(ep));
            9:       run_req("R7", mask, av, int'(ep));
            default: run_req("R3", mask, av, int'(ep));
         endcase
      end

      // R9: results stay after done
      held = rsp_data;
      repeat (4) @(negedge clk);
      check("R9", "data held", 32'(rsp_data !== held), 32'd0);
      check("R9", "passes held", 32'(rsp_passes), 32'd2);

      // R1: write port lands at bank a[3:0], row a[7:4]; row-only difference conflicts
      write_word(8'h37, 32'hDEADBEEF);
      av = '0;
      av[0*AW +: AW] = 8'h07;
      av[1*AW +: AW] = 8'h37;
      av[5*AW +: AW] = 8'h38;
      run_req("R1", 16'h0023, av, 2);
      check("R10", "lane 1 word", rsp_data[1*DW +: DW], 32'hDEADBEEF);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule